// File: doc/BRIEF.md
# Timer Input Capture Channel with Glitch Filter

This block forms one capture channel of a timer. It has two trigger sources: an external capture pin and the output of an analog comparator. A select bit picks one of them. Both sources pass through a synchronizer. The selected level can then go through a four-sample glitch filter, and after that it reaches an edge detector. On the chosen edge the block copies the free-running counter value into a capture register and sets a capture flag. The flag raises an interrupt request when interrupts are enabled.

The flag clears in two ways: when the interrupt is acknowledged, or when software writes a one to the flag. A capture that falls in the same cycle as a clear takes priority, so the flag stays set. The trigger source can change while the two source levels differ, and this produces a capture like any real edge. Software must clear the flag after such a switch. While the timer uses the capture register as its period limit, all captures are blocked.

The captured value and the flag are plain status outputs with no back-pressure. A new capture overwrites the register whether or not the previous value was read, so a consumer that needs every event must service the flag before the next edge.

Top module: `ic_capture_unit`

## Requirements
- R1: On a capture the register `cap_value_o` loads the `cnt_i` value present in the clock cycle before the capturing edge, and `cap_flag_o` sets on that same edge. With the filter off, a source change driven before clock edge E1 is captured at edge E3.
- R2: `edge_rise_i`=1 captures on a 0-to-1 transition of the selected source, and `edge_rise_i`=0 captures on a 1-to-0 transition. The opposite transition leaves both the flag and the register unchanged.
- R3: `src_sel_i`=0 selects `cap_pin_i` and `src_sel_i`=1 selects `cmp_i`. Transitions on the input that is not selected cause no capture.
- R4: With `filt_en_i`=1, a level must hold for four consecutive sampled cycles before the edge detector sees it. The capture then happens four cycles later than with the filter off, at edge E7, and a pulse lasting three cycles or less causes no capture.
- R5: `irq_o` is high exactly when the flag is set and `irq_en_i` is high.
- R6: A cycle with `irq_ack_i`=1 or `flag_wr1_i`=1 and no capture clears the flag on that edge.
- R7: When a capture and a clear request fall in the same cycle, the flag ends up set and the register holds the new value.
- R8: Changing `src_sel_i` while the two synchronized source levels differ counts as an edge of the newly selected source. If that edge matches the edge select, it captures on the next clock edge.
- R9: While `top_mode_i`=1 no capture occurs, and the register and the flag remain unchanged by source activity.
- R10: After reset `cap_value_o`=0, `cap_flag_o`=0 and `irq_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock (undivided) |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | CNT_W | Free-running timer count |
| cap_pin_i | input | 1 | External capture pin, asynchronous |
| cmp_i | input | 1 | Comparator output, asynchronous |
| src_sel_i | input | 1 | Trigger source: 0 pin, 1 comparator |
| edge_rise_i | input | 1 | 1 rising edge, 0 falling edge |
| filt_en_i | input | 1 | Enables the four-sample glitch filter |
| top_mode_i | input | 1 | Capture register in use as period limit; blocks captures |
| irq_en_i | input | 1 | Interrupt enable |
| irq_ack_i | input | 1 | Interrupt acknowledge, clears flag |
| flag_wr1_i | input | 1 | Software write-one-to-clear of flag |
| cap_value_o | output | CNT_W | Captured count |
| cap_flag_o | output | 1 | Capture flag |
| irq_o | output | 1 | Interrupt request |

## Verification
The capture event and the flag clear can land on the same clock edge, and that coincidence is the case most likely to go wrong. The bench first sets the flag with one capture. It then starts a second pin edge and raises the write-one clear in exactly the cycle before the third edge after the change, which is the edge where the second capture lands. It judges the result by requiring the flag to be set afterwards and the register to hold the count of that cycle. In a separate case, a clear with no capture must drop the flag.

// File: rtl/ic_pkg.sv
package ic_pkg;
  localparam int unsigned IC_SYNC_STAGES = 2;
  localparam int unsigned IC_FILT_TAPS   = 4;
  typedef enum logic { SRC_PIN = 1'b0, SRC_CMP = 1'b1 } ic_src_e;
endpackage

// File: rtl/ic_sync.sv
module ic_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= {chain_q[STAGES-2:0], d_i};
  end

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/ic_filter.sv
module ic_filter #(
  parameter int unsigned TAPS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic d_i,
  output logic q_o
);
  logic [TAPS-1:0] hist_q;
  logic            held_q;
  logic            agreed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hist_q <= '0;
      held_q <= 1'b0;
    end else begin
      hist_q <= {hist_q[TAPS-2:0], d_i};
      held_q <= q_o;
    end
  end

  // Output moves only once every tap holds the same level.
  always_comb begin
    if (&hist_q)       agreed = 1'b1;
    else if (~|hist_q) agreed = 1'b0;
    else               agreed = held_q;
  end

  assign q_o = en_i ? agreed : d_i;
endmodule

// File: rtl/ic_edge.sv
module ic_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl_i,
  input  logic rise_i,
  output logic hit_o
);
  logic prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= lvl_i;
  end

  assign hit_o = rise_i ? (lvl_i & ~prev_q) : (~lvl_i & prev_q);
endmodule

// File: rtl/ic_capture_unit.sv
module ic_capture_unit #(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned SYNC_STAGES = ic_pkg::IC_SYNC_STAGES,
  parameter int unsigned FILT_TAPS   = ic_pkg::IC_FILT_TAPS
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             cap_pin_i,
  input  logic             cmp_i,
  input  logic             src_sel_i,
  input  logic             edge_rise_i,
  input  logic             filt_en_i,
  input  logic             top_mode_i,
  input  logic             irq_en_i,
  input  logic             irq_ack_i,
  input  logic             flag_wr1_i,
  output logic [CNT_W-1:0] cap_value_o,
  output logic             cap_flag_o,
  output logic             irq_o
);
  import ic_pkg::*;

  localparam int unsigned NSRC = 2;

  logic [NSRC-1:0] raw_src;
  logic [NSRC-1:0] sync_src;
  logic            sel_lvl;
  logic            filt_lvl;
  logic            edge_hit;
  logic            cap_evt;
  logic [CNT_W-1:0] cap_q;
  logic            flag_q;

  assign raw_src[SRC_PIN] = cap_pin_i;
  assign raw_src[SRC_CMP] = cmp_i;

  for (genvar g = 0; g < NSRC; g++) begin : g_sync
    ic_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_src[g]),
      .q_o   (sync_src[g])
    );
  end

  // Source mux sits ahead of the filter, so a switch looks like an edge.
  assign sel_lvl = (ic_src_e'(src_sel_i) == SRC_CMP) ? sync_src[SRC_CMP] : sync_src[SRC_PIN];

  ic_filter #(.TAPS(FILT_TAPS)) u_filt (
    .clk   (clk),
    .rst_n (rst_n),
    .en_i  (filt_en_i),
    .d_i   (sel_lvl),
    .q_o   (filt_lvl)
  );

  ic_edge u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (filt_lvl),
    .rise_i (edge_rise_i),
    .hit_o  (edge_hit)
  );

  assign cap_evt = edge_hit & ~top_mode_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      if (cap_evt) cap_q <= cnt_i;
      // Capture has priority over both clear paths.
      if (cap_evt)                      flag_q <= 1'b1;
      else if (irq_ack_i || flag_wr1_i) flag_q <= 1'b0;
    end
  end

  assign cap_value_o = cap_q;
  assign cap_flag_o  = flag_q;
  assign irq_o       = flag_q & irq_en_i;
endmodule

// File: rtl/ic_capture_chk.sv
module ic_capture_chk #(
  parameter int unsigned CNT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cnt_i,
  input logic             top_mode_i,
  input logic             irq_ack_i,
  input logic             flag_wr1_i,
  input logic             cap_evt,
  input logic [CNT_W-1:0] cap_value_o,
  input logic             cap_flag_o,
  input logic             irq_o
);
  assert_capture_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cap_evt |=> (cap_flag_o && cap_value_o == $past(cnt_i)));

  assert_irq_needs_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> cap_flag_o);

  assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_flag_o && !cap_evt && (irq_ack_i || flag_wr1_i)) |=> !cap_flag_o);

  assert_capture_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_evt && (flag_wr1_i || irq_ack_i)) |=> cap_flag_o);

  assert_blocked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    top_mode_i |=> $stable(cap_value_o));
endmodule

bind ic_capture_unit ic_capture_chk #(.CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .cnt_i       (cnt_i),
  .top_mode_i  (top_mode_i),
  .irq_ack_i   (irq_ack_i),
  .flag_wr1_i  (flag_wr1_i),
  .cap_evt     (cap_evt),
  .cap_value_o (cap_value_o),
  .cap_flag_o  (cap_flag_o),
  .irq_o       (irq_o)
);

// File: tb/sim_ic_capture_unit.sv
module sim_ic_capture_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cnt = '0;
  logic        pin = 1'b0, cmp = 1'b0, src = 1'b0, rise = 1'b1, filt = 1'b0;
  logic        top = 1'b0, irq_en = 1'b0, ack = 1'b0, wr1 = 1'b0;
  logic [15:0] cap_value;
  logic        cap_flag, irq;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;
  always @(posedge clk) cnt <= cnt + 16'd1;

  ic_capture_unit u0 (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt), .cap_pin_i(pin), .cmp_i(cmp),
    .src_sel_i(src), .edge_rise_i(rise), .filt_en_i(filt), .top_mode_i(top),
    .irq_en_i(irq_en), .irq_ack_i(ack), .flag_wr1_i(wr1),
    .cap_value_o(cap_value), .cap_flag_o(cap_flag), .irq_o(irq)
  );

  // Fields: [8] src, [7] rising, [6] filter, [5] pin toggles, [4] cmp toggles, [3:0] expected latency (0 = none)
  localparam logic [8:0] VEC [8] = '{
    9'b0_1_0_1_0_0011,
    9'b0_0_0_1_0_0011,
    9'b1_1_0_0_1_0011,
    9'b0_1_1_1_0_0111,
    9'b1_0_1_0_1_0111,
    9'b0_1_0_0_1_0000,
    9'b1_1_0_1_0_0000,
    9'b1_1_1_1_1_0111
  };

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic settle_clear();
    tick(10);
    wr1 = 1'b1;
    tick(1);
    wr1 = 1'b0;
    tick(1);
  endtask

  initial begin
    #4000000;
    bad++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int          got;
    logic [15:0] c0, val;
    logic [8:0]  w;
    string       tag;

    tick(3);
    // R10 reset state
    chk(cap_value == 0, "R10 value", cap_value, 0);
    chk(cap_flag == 0, "R10 flag", cap_flag, 0);
    chk(irq == 0, "R10 irq", irq, 0);
    rst_n = 1'b1;
    tick(2);

    for (int v = 0; v < 8; v++) begin
      w = VEC[v];
      src = w[8]; rise = w[7]; filt = w[6];
      pin = ~rise; cmp = ~rise;
      settle_clear();
      c0 = cnt;
      if (w[5]) pin = rise;
      if (w[4]) cmp = rise;
      got = 0; val = '0;
      for (int i = 1; i <= 10; i++) begin
        tick(1);
        if (cap_flag && got == 0) begin got = i; val = cap_value; end
      end
      tag = (w[3:0] == 0) ? "R3" : (w[6] ? "R4" : "R2");
      chk(got == int'(w[3:0]), tag, got, w[3:0]);
      if (w[3:0] != 0)
        chk(val == c0 + 16'(w[3:0]) - 16'd1, "R1 value", val, c0 + 16'(w[3:0]) - 16'd1);
    end

    // R4: three-cycle glitch is swallowed by the filter
    src = 1'b0; rise = 1'b1; filt = 1'b1; pin = 1'b0; cmp = 1'b0;
    settle_clear();
    pin = 1'b1; tick(3); pin = 1'b0; tick(10);
    chk(cap_flag == 0, "R4 glitch", cap_flag, 0);
    // R1: same single-cycle pulse captures without filter
    filt = 1'b0; settle_clear();
    pin = 1'b1; tick(1); pin = 1'b0; tick(4);
    chk(cap_flag == 1, "R1 pulse", cap_flag, 1);

    // R5 and R6 via acknowledge
    irq_en = 1'b0; tick(1);
    chk(irq == 0, "R5 masked", irq, 0);
    irq_en = 1'b1; tick(1);
    chk(irq == 1, "R5 raised", irq, 1);
    ack = 1'b1; tick(1); ack = 1'b0;
    chk(cap_flag == 0 && irq == 0, "R6 ack", cap_flag, 0);
    irq_en = 1'b0;

    // R6 via write-one
    pin = 1'b1; tick(4);
    chk(cap_flag == 1, "R1 set", cap_flag, 1);
    wr1 = 1'b1; tick(1); wr1 = 1'b0;
    chk(cap_flag == 0, "R6 wr1", cap_flag, 0);

    // R2: falling transition ignored in rising mode, flag and value held
    pin = 1'b0; tick(1); pin = 1'b1; tick(4);
    val = cap_value;
    pin = 1'b0; tick(6);
    chk(cap_value == val && cap_flag == 1, "R2 wrong edge", cap_value, val);

    // R7: capture coincides with write-one clear
    c0 = cnt;
    pin = 1'b1; tick(2);
    wr1 = 1'b1; tick(1); wr1 = 1'b0;
    chk(cap_flag == 1, "R7 flag", cap_flag, 1);
    chk(cap_value == c0 + 16'd2, "R7 value", cap_value, c0 + 16'd2);

    // R8: source switch with differing levels
    pin = 1'b1; cmp = 1'b0; src = 1'b1; rise = 1'b1;
    settle_clear();
    c0 = cnt;
    src = 1'b0; tick(1);
    chk(cap_flag == 1, "R8 flag", cap_flag, 1);
    chk(cap_value == c0, "R8 value", cap_value, c0);

    // R9: period-limit mode blocks capture
    pin = 1'b0; settle_clear();
    top = 1'b1; val = cap_value;
    pin = 1'b1; tick(10);
    chk(cap_flag == 0 && cap_value == val, "R9 blocked", cap_flag, 0);
    top = 1'b0; tick(2);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule